// File: doc/BRIEF.md
# Spread-Spectrum Correlator Channel

This block is a single despreading channel for a satellite ranging receiver. It takes one sign/magnitude IF sample per sample strobe and removes the carrier with its own phase-accumulator oscillator. The result is an in-phase and a quadrature baseband value. Each of these is multiplied by three copies of a locally generated 1023-chip Gold code replica: early, prompt and late, spaced half a chip apart. The products are summed into six running totals. The replica is clocked by a second phase accumulator, whose nominal rate is 1.023 Mchip/s relative to the sample rate.

When the replica completes a code period, the six totals are copied into holding outputs and the running sums restart. A ready flag tells the processor that a fresh set of results exists. Software acknowledges the read, and the totals feed its navigation-data and tracking-loop code. A small write port sets the carrier and code rate words, selects the replica, and commands a code-phase slew. The replica can be either a tap-pair code or a code obtained from a programmed start state of the second register. The second form covers augmentation-system ranging codes.

Top module: `gnss_corr_chan`

## Requirements
- R1: After reset, dump_ready and dump_overrun are 0 and all six holding outputs are 0. Both phase accumulators are 0. Both shift registers are all ones. The code select is tap pair (2,6), and the rate words and the slew count are 0.
- R2: A sample is +1 or +3 for sign=0 and mag=0/1, and -1 or -3 for sign=1. I = sample*cos and Q = sample*sin. The carrier octant k (0..7) maps to cos = {2,1,-1,-2,-2,-1,1,2}[k] and sin = {1,2,2,1,-1,-2,-2,-1}[k].
- R3: The carrier octant is bits 31:29 of a 32-bit phase. Each accepted sample uses the current phase, and the phase then grows by the carrier word. The phase does not move while smp_en is 0.
- R4: Stage 1 of each 10-stage register takes the feedback. G1 feedback is stage3^stage10. G2 feedback is XOR of stages 2,3,6,8,9,10. Both shift once per chip tick. In tap mode the early chip is G1[10]^G2[a]^G2[b], where a = select[7:4] and b = select[3:0] (a value outside 1..10 contributes 0). Chip bit 0 means +1 and chip bit 1 means -1.
- R5: With select bit 16 set, G2 is loaded from select[9:0] (bit i is stage i+1) and the early chip is G1[10]^G2[10].
- R6: The code phase is 32 bits and grows by the code word on each sample. A half-chip tick happens when bit 31 changes, and a chip tick when the sum carries out. The code word must stay below 2^31.
- R7: Early is the generator output. On each half-chip tick, prompt takes the early value and late takes the old prompt value.
- R8: A chip tick that arrives while the chip count is 1022 ends the epoch. The holding outputs receive the running sums including that sample. The sums clear, the count returns to 0, and dump_ready is 1 in the next cycle.
- R9: dump_ack clears dump_ready. If an epoch ends in the same cycle as dump_ack, the new dump wins: dump_ready stays 1 and no overrun is recorded.
- R10: An epoch ending while dump_ready is 1 and dump_ack is 0 sets dump_overrun. dump_overrun stays set until the code select is written.
- R11: Writing the code select (address 2) restarts the code. Both phases of the code go to 0, G1 is all ones, and G2 is all ones or the preset. Prompt, late, the count and the slew all go to 0. The running sums, dump_ready and dump_overrun clear, and the holding outputs are kept.
- R12: Writing address 3 loads a slew count N (bits 10:0). The next N half-chip ticks are swallowed: prompt, late, the registers and the chip count hold while the code phase still advances.
- R13: Address 0 sets the carrier word and address 1 sets the code word. A write is used from the next accepted sample on. While smp_en is 0, the sums and holding outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 carrier word, 1 code word, 2 code select, 3 slew count |
| cfg_wdata | input | 32 | Write data |
| smp_en | input | 1 | Sample strobe |
| smp_sign | input | 1 | Sample sign (1 = negative) |
| smp_mag | input | 1 | Sample magnitude (1 = large) |
| dump_ack | input | 1 | Processor has read the holding outputs |
| dump_ready | output | 1 | New epoch results are held |
| dump_overrun | output | 1 | Sticky: a dump replaced unread results |
| hold_ei | output | ACC_W | Early in-phase total |
| hold_eq | output | ACC_W | Early quadrature total |
| hold_pi | output | ACC_W | Prompt in-phase total |
| hold_pq | output | ACC_W | Prompt quadrature total |
| hold_li | output | ACC_W | Late in-phase total |
| hold_lq | output | ACC_W | Late quadrature total |

## Verification
The epoch dump and the processor acknowledge can land in the same cycle. The bench provokes this by predicting, from its own arithmetic model of the code phase and chip count, the exact sample that ends the next epoch, and raising dump_ack in that cycle. It then expects dump_ready to remain 1 and dump_overrun to stay 0. A slew that swallows a half-chip tick, coinciding with what would have been the epoch-ending chip, is also swept, and the dump is expected to arrive later.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

    localparam int G_STAGES = 10;
    localparam int CODE_LEN = 1023;

    typedef logic signed [2:0] lvl_t;

    // octant-centred cosine levels
    function automatic lvl_t cos8(input logic [2:0] oct);
        case (oct)
            3'd0, 3'd7: cos8 = 3'sd2;
            3'd1, 3'd6: cos8 = 3'sd1;
            3'd2, 3'd5: cos8 = -3'sd1;
            default:    cos8 = -3'sd2;
        endcase
    endfunction

    function automatic lvl_t sin8(input logic [2:0] oct);
        case (oct)
            3'd0, 3'd3: sin8 = 3'sd1;
            3'd1, 3'd2: sin8 = 3'sd2;
            3'd4, 3'd7: sin8 = -3'sd1;
            default:    sin8 = -3'sd2;
        endcase
    endfunction

    // pick stage idx (1..10) of a shift register, 0 outside that range
    function automatic logic stage_pick(input logic [10:1] g, input logic [3:0] idx);
        logic [10:0] gx;
        gx = {g, 1'b0};
        stage_pick = (idx <= 4'd10) ? gx[idx] : 1'b0;
    endfunction

endpackage

// File: rtl/gcc_carrier_nco.sv
module gcc_carrier_nco
    import gcc_pkg::*;
#(
    parameter int PH_W  = 32,
    parameter int IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_en,
    input  logic [PH_W-1:0] fcw,
    output lvl_t            cos_o,
    output lvl_t            sin_o
);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } nco_st_t;

    nco_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.ph = st_q.ph + fcw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (IDX_W >= 3) begin : g_oct
            assign cos_o = cos8(st_q.ph[PH_W-1 -: 3]);
            assign sin_o = sin8(st_q.ph[PH_W-1 -: 3]);
        end else begin : g_quad
            logic [1:0] quad;
            assign quad  = st_q.ph[PH_W-1 -: 2];
            assign cos_o = (quad == 2'd1 || quad == 2'd2) ? -3'sd1 : 3'sd1;
            assign sin_o = quad[1] ? -3'sd1 : 3'sd1;
        end
    endgenerate

    // R3
    car_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(st_q.ph));

endmodule

// File: rtl/gcc_code_gen.sv
module gcc_code_gen
    import gcc_pkg::*;
#(
    parameter int PH_W   = 32,
    parameter int SLEW_W = 11,
    parameter int CNT_W  = $clog2(CODE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              restart,
    input  logic [PH_W-1:0]   fcw,
    input  logic              sel_preset,
    input  logic [9:0]        sel_val,
    input  logic              slew_ld,
    input  logic [SLEW_W-1:0] slew_val,
    output logic              early_o,
    output logic              prompt_o,
    output logic              late_o,
    output logic              epoch_o
);

    localparam logic [CNT_W-1:0] LAST_CHIP = CNT_W'(CODE_LEN - 1);

    typedef struct packed {
        logic [PH_W-1:0]   ph;
        logic [10:1]       g1;
        logic [10:1]       g2;
        logic [CNT_W-1:0]  cnt;
        logic              p;
        logic              l;
        logic [SLEW_W-1:0] slew;
    } code_st_t;

    code_st_t st_d, st_q;

    logic [PH_W:0] sum;
    logic          half, chip, swallow;
    logic          g1_fb, g2_fb;

    always_comb begin
        sum     = {1'b0, st_q.ph} + {1'b0, fcw};
        half    = sum[PH_W-1] ^ st_q.ph[PH_W-1];
        chip    = sum[PH_W];
        swallow = half && (st_q.slew != '0);
        g1_fb   = st_q.g1[3] ^ st_q.g1[10];
        g2_fb   = st_q.g2[2] ^ st_q.g2[3] ^ st_q.g2[6] ^ st_q.g2[8] ^ st_q.g2[9] ^ st_q.g2[10];
        if (sel_preset) begin
            early_o = st_q.g1[10] ^ st_q.g2[10];
        end else begin
            early_o = st_q.g1[10] ^ stage_pick(st_q.g2, sel_val[7:4])
                                  ^ stage_pick(st_q.g2, sel_val[3:0]);
        end
        epoch_o = smp_en && !restart && chip && !swallow && (st_q.cnt == LAST_CHIP);

        st_d = st_q;
        if (restart) begin
            st_d.ph   = '0;
            st_d.g1   = '1;
            st_d.g2   = sel_preset ? sel_val : '1;
            st_d.cnt  = '0;
            st_d.p    = 1'b0;
            st_d.l    = 1'b0;
            st_d.slew = '0;
        end else begin
            if (smp_en) begin
                st_d.ph = sum[PH_W-1:0];
                if (swallow) begin
                    st_d.slew = st_q.slew - SLEW_W'(1);
                end else if (half) begin
                    st_d.l = st_q.p;
                    st_d.p = early_o;
                    if (chip) begin
                        st_d.g1  = {st_q.g1[9:1], g1_fb};
                        st_d.g2  = {st_q.g2[9:1], g2_fb};
                        st_d.cnt = (st_q.cnt == LAST_CHIP) ? '0 : st_q.cnt + CNT_W'(1);
                    end
                end
            end
            if (slew_ld) begin
                st_d.slew = slew_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.g1   <= '1;
            st_q.g2   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign prompt_o = st_q.p;
    assign late_o   = st_q.l;

    // R7
    late_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && half && !swallow && !restart) |=> (late_o == $past(prompt_o)));

    // R12
    slew_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && swallow && !restart) |=> ($stable(prompt_o) && $stable(late_o) && $stable(st_q.cnt)));

    // R8
    chip_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_o && !slew_ld) |=> (st_q.cnt == '0));

endmodule

// File: rtl/gcc_accum.sv
module gcc_accum
    import gcc_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_en,
    input  logic                   restart,
    input  logic                   ack,
    input  logic                   smp_sign,
    input  logic                   smp_mag,
    input  lvl_t                   cos_i,
    input  lvl_t                   sin_i,
    input  logic                   early_i,
    input  logic                   prompt_i,
    input  logic                   late_i,
    input  logic                   epoch_i,
    output logic [5:0][ACC_W-1:0]  hold_o,
    output logic                   ready_o,
    output logic                   overrun_o
);

    localparam int N_ACC = 6;

    typedef struct packed {
        logic [N_ACC-1:0][ACC_W-1:0] acc;
        logic [N_ACC-1:0][ACC_W-1:0] hold;
        logic                        ready;
        logic                        ovr;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic signed [5:0] x6, c6, s6, bi, bq;
    logic        [2:0] rep;
    logic signed [5:0] prod [N_ACC];
    logic [N_ACC-1:0][ACC_W-1:0] ext;

    always_comb begin
        x6  = smp_mag ? 6'sd3 : 6'sd1;
        if (smp_sign) x6 = -x6;
        c6  = 6'(cos_i);
        s6  = 6'(sin_i);
        bi  = x6 * c6;
        bq  = x6 * s6;
        rep = {late_i, prompt_i, early_i};
        for (int k = 0; k < N_ACC; k++) begin
            prod[k] = (k % 2 == 1) ? bq : bi;
            if (rep[k/2]) prod[k] = -prod[k];
            ext[k]  = ACC_W'(prod[k]);
        end

        st_d = st_q;
        if (restart) begin
            st_d.acc   = '0;
            st_d.ready = 1'b0;
            st_d.ovr   = 1'b0;
        end else if (smp_en && epoch_i) begin
            for (int k = 0; k < N_ACC; k++) begin
                st_d.hold[k] = st_q.acc[k] + ext[k];
            end
            st_d.acc   = '0;
            st_d.ready = 1'b1;
            if (st_q.ready && !ack) st_d.ovr = 1'b1;
        end else begin
            if (smp_en) begin
                for (int k = 0; k < N_ACC; k++) begin
                    st_d.acc[k] = st_q.acc[k] + ext[k];
                end
            end
            if (ack) st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o    = st_q.hold;
    assign ready_o   = st_q.ready;
    assign overrun_o = st_q.ovr;

    // R8
    dump_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && epoch_i && !restart) |=> ready_o);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(smp_en && epoch_i) && !restart) |=> !ready_o);

    // R9
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && epoch_i && ack && !overrun_o && !restart) |=> (ready_o && !overrun_o));

    // R10
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && epoch_i && ready_o && !ack && !restart) |=> overrun_o);

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !restart) |=> overrun_o);

    // R11
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!ready_o && !overrun_o && $stable(hold_o)));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !restart) |=> ($stable(st_q.acc) && $stable(hold_o)));

endmodule

// File: rtl/gnss_corr_chan.sv
module gnss_corr_chan
    import gcc_pkg::*;
#(
    parameter int ACC_W  = 20,
    parameter int PH_W   = 32,
    parameter int SLEW_W = 11,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_addr,
    input  logic [31:0]             cfg_wdata,
    input  logic                    smp_en,
    input  logic                    smp_sign,
    input  logic                    smp_mag,
    input  logic                    dump_ack,
    output logic                    dump_ready,
    output logic                    dump_overrun,
    output logic signed [ACC_W-1:0] hold_ei,
    output logic signed [ACC_W-1:0] hold_eq,
    output logic signed [ACC_W-1:0] hold_pi,
    output logic signed [ACC_W-1:0] hold_pq,
    output logic signed [ACC_W-1:0] hold_li,
    output logic signed [ACC_W-1:0] hold_lq
);

    localparam logic [1:0] A_CAR  = 2'd0;
    localparam logic [1:0] A_CODE = 2'd1;
    localparam logic [1:0] A_SEL  = 2'd2;
    localparam logic [1:0] A_SLEW = 2'd3;

    typedef struct packed {
        logic [PH_W-1:0] car_fcw;
        logic [PH_W-1:0] code_fcw;
        logic            preset;
        logic [9:0]      sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic       restart, slew_ld, sel_preset_w;
    logic [9:0] sel_w;

    always_comb begin
        restart = cfg_we && (cfg_addr == A_SEL);
        slew_ld = cfg_we && (cfg_addr == A_SLEW);
        cfg_d   = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                A_CAR:   cfg_d.car_fcw  = cfg_wdata[PH_W-1:0];
                A_CODE:  cfg_d.code_fcw = cfg_wdata[PH_W-1:0];
                A_SEL: begin
                    cfg_d.preset = cfg_wdata[16];
                    cfg_d.sel    = cfg_wdata[9:0];
                end
                default: ;
            endcase
        end
        sel_preset_w = restart ? cfg_wdata[16]  : cfg_q.preset;
        sel_w        = restart ? cfg_wdata[9:0] : cfg_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.sel <= 10'h026;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    lvl_t cos_w, sin_w;
    logic early_w, prompt_w, late_w, epoch_w;
    logic [5:0][ACC_W-1:0] hold_w;

    gcc_carrier_nco #(.PH_W(PH_W), .IDX_W(IDX_W)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .fcw    (cfg_q.car_fcw),
        .cos_o  (cos_w),
        .sin_o  (sin_w)
    );

    gcc_code_gen #(.PH_W(PH_W), .SLEW_W(SLEW_W)) u_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_en     (smp_en),
        .restart    (restart),
        .fcw        (cfg_q.code_fcw),
        .sel_preset (sel_preset_w),
        .sel_val    (sel_w),
        .slew_ld    (slew_ld),
        .slew_val   (cfg_wdata[SLEW_W-1:0]),
        .early_o    (early_w),
        .prompt_o   (prompt_w),
        .late_o     (late_w),
        .epoch_o    (epoch_w)
    );

    gcc_accum #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .restart   (restart),
        .ack       (dump_ack),
        .smp_sign  (smp_sign),
        .smp_mag   (smp_mag),
        .cos_i     (cos_w),
        .sin_i     (sin_w),
        .early_i   (early_w),
        .prompt_i  (prompt_w),
        .late_i    (late_w),
        .epoch_i   (epoch_w),
        .hold_o    (hold_w),
        .ready_o   (dump_ready),
        .overrun_o (dump_overrun)
    );

    assign hold_ei = hold_w[0];
    assign hold_eq = hold_w[1];
    assign hold_pi = hold_w[2];
    assign hold_pq = hold_w[3];
    assign hold_li = hold_w[4];
    assign hold_lq = hold_w[5];

    // R13
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_CAR) |=> (cfg_q.car_fcw == $past(cfg_wdata[PH_W-1:0])));

endmodule

// File: tb/gnss_corr_chan_test.sv
module gnss_corr_chan_test;

    localparam int ACC_W = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cfg_we, smp_en, smp_sign, smp_mag, dump_ack;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        dump_ready, dump_overrun;
    logic signed [ACC_W-1:0] h_ei, h_eq, h_pi, h_pq, h_li, h_lq;

    gnss_corr_chan #(.ACC_W(ACC_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .smp_en(smp_en), .smp_sign(smp_sign), .smp_mag(smp_mag), .dump_ack(dump_ack),
        .dump_ready(dump_ready), .dump_overrun(dump_overrun),
        .hold_ei(h_ei), .hold_eq(h_eq), .hold_pi(h_pi), .hold_pq(h_pq), .hold_li(h_li), .hold_lq(h_lq)
    );

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";

    // independent arithmetic model
    int cos_t [8] = '{2, 1, -1, -2, -2, -1, 1, 2};
    int sin_t [8] = '{1, 2, 2, 1, -1, -2, -2, -1};
    logic [31:0] m_car_f, m_code_f, m_car, m_code;
    logic        m_pre;
    logic [9:0]  m_sel;
    logic [10:1] m_g1, m_g2;
    int          m_cnt, m_slew;
    logic        m_p, m_l, m_rdy, m_ovr;
    int          m_acc [6];
    int          m_hold [6];
    logic [15:0] rng = 16'hACE1;

    function automatic logic pick(input logic [10:1] g, input int idx);
        return (idx >= 1 && idx <= 10) ? g[idx] : 1'b0;
    endfunction

    function automatic logic m_chip();
        if (m_pre) return m_g1[10] ^ m_g2[10];
        return m_g1[10] ^ pick(m_g2, int'(m_sel[7:4])) ^ pick(m_g2, int'(m_sel[3:0]));
    endfunction

    function automatic logic next_is_epoch();
        logic [32:0] sm;
        logic hf;
        sm = {1'b0, m_code} + {1'b0, m_code_f};
        hf = sm[31] ^ m_code[31];
        return sm[32] && !(hf && m_slew != 0) && (m_cnt == 1022);
    endfunction

    task automatic m_restart();
        m_code = '0; m_g1 = '1; m_g2 = m_pre ? m_sel : '1;
        m_cnt = 0; m_p = 0; m_l = 0; m_slew = 0;
        for (int k = 0; k < 6; k++) m_acc[k] = 0;
        m_rdy = 0; m_ovr = 0;
    endtask

    task automatic m_reset();
        m_car_f = 0; m_code_f = 0; m_car = 0; m_pre = 0; m_sel = 10'h026;
        m_restart();
        for (int k = 0; k < 6; k++) m_hold[k] = 0;
    endtask

    task automatic m_step(input logic s, input logic sg, input logic mg, input logic a);
        int x, bi, bq, v;
        int pr [6];
        logic [32:0] sm;
        logic hf, cy, sw, ep, e, rp;
        if (!s) begin
            if (a) m_rdy = 0;
            return;
        end
        x  = mg ? 3 : 1;
        if (sg) x = -x;
        bi = x * cos_t[m_car[31:29]];
        bq = x * sin_t[m_car[31:29]];
        e  = m_chip();
        for (int k = 0; k < 6; k++) begin
            rp = (k < 2) ? e : (k < 4) ? m_p : m_l;
            v  = (k % 2 == 1) ? bq : bi;
            pr[k] = rp ? -v : v;
        end
        sm = {1'b0, m_code} + {1'b0, m_code_f};
        hf = sm[31] ^ m_code[31];
        cy = sm[32];
        sw = hf && (m_slew != 0);
        ep = cy && !sw && (m_cnt == 1022);
        if (ep) begin
            if (m_rdy && !a) m_ovr = 1;
            m_rdy = 1;
            for (int k = 0; k < 6; k++) begin m_hold[k] = m_acc[k] + pr[k]; m_acc[k] = 0; end
        end else begin
            for (int k = 0; k < 6; k++) m_acc[k] += pr[k];
            if (a) m_rdy = 0;
        end
        m_car  = m_car + m_car_f;
        m_code = sm[31:0];
        if (sw) m_slew--;
        else if (hf) begin
            m_l = m_p; m_p = e;
            if (cy) begin
                m_g1  = {m_g1[9:1], m_g1[3] ^ m_g1[10]};
                m_g2  = {m_g2[9:1], m_g2[2] ^ m_g2[3] ^ m_g2[6] ^ m_g2[8] ^ m_g2[9] ^ m_g2[10]};
                m_cnt = (m_cnt == 1022) ? 0 : m_cnt + 1;
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmp(input string req);
        int dv [6];
        dv[0] = int'(h_ei); dv[1] = int'(h_eq); dv[2] = int'(h_pi);
        dv[3] = int'(h_pq); dv[4] = int'(h_li); dv[5] = int'(h_lq);
        n_chk++;
        if (dump_ready !== m_rdy || dump_overrun !== m_ovr) begin
            n_bad++;
            $display("FAIL %s flags actual=%0b%0b expected=%0b%0b", req, dump_ready, dump_overrun, m_rdy, m_ovr);
        end else begin
            for (int k = 0; k < 6; k++) begin
                if (dv[k] != m_hold[k]) begin
                    n_bad++;
                    $display("FAIL %s hold[%0d] actual=%0d expected=%0d", req, k, dv[k], m_hold[k]);
                    break;
                end
            end
        end
    endtask

    task automatic cyc(input logic s, input logic a);
        logic sg, mg;
        rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
        sg = rng[0]; mg = rng[7];
        cfg_we = 0; smp_en = s; smp_sign = sg; smp_mag = mg; dump_ack = a;
        @(posedge clk);
        m_step(s, sg, mg, a);
        @(negedge clk);
        cmp(cur_req);
    endtask

    task automatic wr(input logic [1:0] ad, input logic [31:0] d);
        cfg_we = 1; cfg_addr = ad; cfg_wdata = d; smp_en = 0; dump_ack = 0;
        @(posedge clk);
        case (ad)
            2'd0: m_car_f = d;
            2'd1: m_code_f = d;
            2'd2: begin m_pre = d[16]; m_sel = d[9:0]; m_restart(); end
            default: m_slew = int'(d[10:0]);
        endcase
        @(negedge clk);
        cfg_we = 0;
        cmp(cur_req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired during %s actual=hung expected=done", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        smp_en = 0; smp_sign = 0; smp_mag = 0; dump_ack = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        cmp("R1");
        chk(dump_ready == 0 && dump_overrun == 0, "R1", "flags", int'({dump_ready, dump_overrun}), 0);

        // R4 tap-pair code (2,6), still carrier, about two samples per chip
        cur_req = "R4";
        wr(2'd1, 32'h7FFF_FFFF);
        wr(2'd2, 32'h0000_0026);
        for (int i = 0; i < 4300; i++) cyc(1'b1, m_rdy);

        // R2 R3 rotating carrier, taps (3,7), gapped samples
        cur_req = "R2";
        wr(2'd0, 32'h2000_0155);
        wr(2'd1, 32'h4000_0000);
        wr(2'd2, 32'h0000_0037);
        for (int i = 0; i < 9000; i++) cyc((i % 4) != 3, m_rdy);

        // R6 R7 uneven code rate, half-chip spacing
        cur_req = "R6";
        wr(2'd1, 32'h5A5A_5A5A);
        for (int i = 0; i < 5000; i++) cyc(1'b1, m_rdy);

        // R5 preset start state
        cur_req = "R5";
        wr(2'd1, 32'h7FFF_FFFF);
        wr(2'd2, 32'h0001_01B5);
        for (int i = 0; i < 4300; i++) cyc(1'b1, m_rdy);

        // R10 unread dumps build an overrun that sticks
        cur_req = "R10";
        for (int i = 0; i < 4300; i++) cyc(1'b1, 1'b0);
        chk(dump_overrun == 1'b1, "R10", "overrun set", int'(dump_overrun), 1);
        for (int i = 0; i < 50; i++) cyc(1'b1, 1'b1);
        chk(dump_overrun == 1'b1 && dump_ready == 1'b0, "R10", "overrun sticky after ack",
            int'({dump_overrun, dump_ready}), 2);

        // R11 code-select write restarts and clears flags
        cur_req = "R11";
        wr(2'd2, 32'h0000_0015);
        chk(dump_overrun == 1'b0 && dump_ready == 1'b0, "R11", "flags after restart",
            int'({dump_overrun, dump_ready}), 0);
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0);

        // R9 ack arriving in the same cycle as a dump
        cur_req = "R9";
        while (!m_rdy) cyc(1'b1, 1'b0);
        while (!next_is_epoch()) cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        chk(dump_ready == 1'b1 && dump_overrun == 1'b0, "R9", "collision ready/overrun",
            int'({dump_ready, dump_overrun}), 2);
        cyc(1'b1, 1'b1);
        chk(dump_ready == 1'b0, "R9", "plain ack", int'(dump_ready), 0);

        // R8 epoch boundary with acks right after each dump
        cur_req = "R8";
        for (int i = 0; i < 4200; i++) cyc(1'b1, m_rdy);

        // R12 slew swallows half-chip ticks, once right before the epoch end
        cur_req = "R12";
        wr(2'd3, 32'd7);
        for (int i = 0; i < 2500; i++) cyc(1'b1, m_rdy);
        while (!next_is_epoch()) cyc(1'b1, m_rdy);
        wr(2'd3, 32'd1);
        for (int i = 0; i < 4300; i++) cyc(1'b1, m_rdy);

        // R13 mid-run rate write and idle cycles
        cur_req = "R13";
        wr(2'd0, 32'h0F00_0F00);
        for (int i = 0; i < 300; i++) cyc(1'b1, m_rdy);
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0);
        for (int i = 0; i < 2500; i++) cyc((i % 3) != 0, m_rdy);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule